// File: doc/BRIEF.md
# Control-transfer history stack

This block keeps a short history of the latest control transfers seen by a processor core. The core's branch logic raises a one-cycle event strobe for each taken branch, interrupt or exception, and supplies the source and destination addresses with it. When recording is switched on in the debug control register, the block stores both addresses as one packed record in a circular store of eight slots. A top-of-stack index always names the slot that holds the newest record, so software can start at that slot and walk backward through older transfers.

Software writes the debug control register through a plain write strobe. A single synchronous read port returns any slot, the top-of-stack index or the control register, one cycle after the address is presented. The control register also keeps four further debug flags (single-step on branches, trace messages, trace store and trace-buffer interrupt). This block only stores them. Every other control bit is reserved.

Top module: `branch_hist_stack`

## Requirements
- R1: The store has 8 slots, used in circular order: after the slot 7 write, the next record goes to slot 0 and overwrites the oldest contents.
- R2: Each slot is a 64-bit word with the source address in bits 31..0 and the destination address in bits 63..32.
- R3: On a recorded event the top-of-stack index first advances by one modulo 8, and the record is then written to the slot it now names. The first record after reset therefore lands in slot 1, and the index always names the newest record.
- R4: Recording is enabled by control bit 0. While that bit is 0, event strobes are ignored and both the slots and the index keep their values.
- R5: A control write stores bits 0, 1, 6, 7 and 8 of the write data. All other control bits are discarded and read as 0.
- R6: Read address map (4 bits): values 0..7 select the slot with that number; 8 selects the index, returned in bits 2..0 with zeros above; 9 selects the control register, zero-extended; 10..15 return all zeros.
- R7: Reads take one cycle. The read data after a rising edge reflects the address presented before that edge and the state held before that edge's updates.
- R8: Reset clears the index, all eight slots, the control register and the read data.
- R9: When a control write and an event arrive in the same cycle, the event is judged by the enable value held before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; the block releases it synchronously |
| ev_valid | input | 1 | One-cycle strobe for a taken branch, interrupt or exception |
| ev_from | input | 32 | Source address of the transfer |
| ev_to | input | 32 | Destination address of the transfer |
| ctl_we | input | 1 | Debug control register write strobe |
| ctl_wdata | input | 32 | Debug control register write data |
| rd_addr | input | 4 | Read select: slot, index or control |
| rd_data | output | 64 | Registered read data |

## Verification
The bench builds the block with its default values: 8 slots, 32-bit addresses and a 4-bit read address. With these values, every read address (including the unused codes) and every slot can be swept in full. The event run is long enough to wrap the store more than twice, so the modulo-8 step of the index and the overwrite of the oldest slot are both reached many times. Writing all ones to the control register covers every reserved bit at once. A mixed event-and-write cycle checks which enable value qualifies the event.

// File: rtl/brh_pkg.sv
package brh_pkg;
  localparam int unsigned CTL_W      = 32;
  localparam int unsigned CTL_EN_BIT = 0;
  // Writable control flags: record enable, single-step, trace msg, trace store, trace irq
  localparam logic [CTL_W-1:0] CTL_MASK = 32'h0000_01C3;
endpackage

// File: rtl/brh_rst_sync.sv
module brh_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [1:0] sync_q;
  logic [1:0] sync_nxt;

  always_comb sync_nxt = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_nxt;
  end

  assign rst_sn = sync_q[1];
endmodule

// File: rtl/brh_ctrl.sv
module brh_ctrl
  import brh_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CTL_W-1:0] wdata,
  output logic [CTL_W-1:0] ctl,
  output logic             rec_en
);
  logic [CTL_W-1:0] ctl_q;
  logic [CTL_W-1:0] ctl_nxt;

  always_comb begin
    ctl_nxt = ctl_q;
    if (we) ctl_nxt = wdata & CTL_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= '0;
    else        ctl_q <= ctl_nxt;
  end

  assign ctl    = ctl_q;
  assign rec_en = ctl_q[CTL_EN_BIT];

  a_r5_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q & ~CTL_MASK) == '0);
  a_r5_write_kept: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> ctl_q == ($past(wdata) & CTL_MASK));
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(ctl_q));
endmodule

// File: rtl/brh_ptr.sv
module brh_ptr #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rec,
  output logic [PTR_W-1:0] ptr,
  output logic [PTR_W-1:0] wr_idx
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [PTR_W-1:0] ptr_q;
  logic [PTR_W-1:0] ptr_inc;
  logic [PTR_W-1:0] ptr_nxt;

  always_comb begin
    ptr_inc = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    ptr_nxt = rec ? ptr_inc : ptr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_nxt;
  end

  assign ptr    = ptr_q;
  assign wr_idx = ptr_inc;

  a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
    rec && ($past(ptr_q) != LAST || !$past(rec)) |=> ptr_q == $past(wr_idx));
  a_r1_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    rec && ptr_q == LAST |=> ptr_q == '0);
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rec |=> $stable(ptr_q));
endmodule

// File: rtl/brh_store.sv
module brh_store #(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned ADDR_W = 32,
  localparam int unsigned PTR_W  = $clog2(DEPTH),
  localparam int unsigned DATA_W = 2 * ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rec,
  input  logic [PTR_W-1:0]  wr_idx,
  input  logic [ADDR_W-1:0] ev_from,
  input  logic [ADDR_W-1:0] ev_to,
  input  logic [PTR_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_entry
);
  logic [DATA_W-1:0] slot_q [DEPTH];
  logic [DEPTH-1:0]  slot_we;
  logic [DATA_W-1:0] wr_word;

  assign wr_word = {ev_to, ev_from};

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [DATA_W-1:0] slot_nxt;
    assign slot_we[g] = rec && (wr_idx == PTR_W'(g));
    always_comb slot_nxt = slot_we[g] ? wr_word : slot_q[g];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slot_q[g] <= '0;
      else        slot_q[g] <= slot_nxt;
    end
  end

  assign rd_entry = slot_q[rd_idx];

  a_r1_single_write: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slot_we));
  a_r2_layout: assert property (@(posedge clk) disable iff (!rst_n)
    rec |=> slot_q[$past(wr_idx)] == {$past(ev_to), $past(ev_from)});
endmodule

// File: rtl/branch_hist_stack.sv
module branch_hist_stack
  import brh_pkg::*;
#(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned ADDR_W = 32,
  localparam int unsigned PTR_W  = $clog2(DEPTH),
  localparam int unsigned RA_W   = PTR_W + 1,
  localparam int unsigned DATA_W = 2 * ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  input  logic [ADDR_W-1:0] ev_from,
  input  logic [ADDR_W-1:0] ev_to,
  input  logic              ctl_we,
  input  logic [CTL_W-1:0]  ctl_wdata,
  input  logic [RA_W-1:0]   rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam logic [RA_W-1:0] RA_PTR = {1'b1, {PTR_W{1'b0}}};
  localparam logic [RA_W-1:0] RA_CTL = RA_PTR + 1'b1;

  logic              rst_sn;
  logic [CTL_W-1:0]  ctl;
  logic              rec_en;
  logic              rec;
  logic [PTR_W-1:0]  ptr;
  logic [PTR_W-1:0]  wr_idx;
  logic [DATA_W-1:0] rd_entry;
  logic [DATA_W-1:0] rd_nxt;
  logic [DATA_W-1:0] rd_q;

  brh_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sn(rst_sn));

  brh_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_sn), .we(ctl_we), .wdata(ctl_wdata),
    .ctl(ctl), .rec_en(rec_en)
  );

  assign rec = ev_valid && rec_en;

  brh_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk(clk), .rst_n(rst_sn), .rec(rec), .ptr(ptr), .wr_idx(wr_idx)
  );

  brh_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_store (
    .clk(clk), .rst_n(rst_sn), .rec(rec), .wr_idx(wr_idx),
    .ev_from(ev_from), .ev_to(ev_to),
    .rd_idx(rd_addr[PTR_W-1:0]), .rd_entry(rd_entry)
  );

  always_comb begin
    if (!rd_addr[RA_W-1])      rd_nxt = rd_entry;
    else if (rd_addr == RA_PTR) rd_nxt = DATA_W'(ptr);
    else if (rd_addr == RA_CTL) rd_nxt = DATA_W'(ctl);
    else                        rd_nxt = '0;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) rd_q <= '0;
    else         rd_q <= rd_nxt;
  end

  assign rd_data = rd_q;

  a_r6_ptr_read: assert property (@(posedge clk) disable iff (!rst_sn)
    rd_addr == RA_PTR |=> rd_data == DATA_W'($past(ptr)));
  a_r6_unused_zero: assert property (@(posedge clk) disable iff (!rst_sn)
    rd_addr[RA_W-1] && rd_addr > RA_CTL |=> rd_data == '0);
  a_r4_ignore: assert property (@(posedge clk) disable iff (!rst_sn)
    ev_valid && !ctl[CTL_EN_BIT] |=> $stable(ptr));
endmodule

// File: tb/test_branch_hist_stack.sv
module test_branch_hist_stack;
  logic        clk;
  logic        rst_n;
  logic        ev_valid;
  logic [31:0] ev_from;
  logic [31:0] ev_to;
  logic        ctl_we;
  logic [31:0] ctl_wdata;
  logic [3:0]  rd_addr;
  logic [63:0] rd_data;

  int unsigned n_vec;
  int unsigned n_bad;
  bit          done;

  logic [63:0] m_slot [8];
  int unsigned m_ptr;
  logic [31:0] m_ctl;

  branch_hist_stack i_branch_hist_stack (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_from(ev_from),
    .ev_to(ev_to), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive at negedge, capture at posedge, sample at next negedge
  task automatic rd_chk(input logic [3:0] a, input string req);
    logic [63:0] exp;
    if (a < 4'd8)       exp = m_slot[a[2:0]];
    else if (a == 4'd8) exp = 64'(m_ptr);
    else if (a == 4'd9) exp = 64'(m_ctl);
    else                exp = '0;
    rd_addr = a;
    @(negedge clk);
    check(req, rd_data, exp);
  endtask

  task automatic cycle(input bit ev, input logic [31:0] f, input logic [31:0] t,
                       input bit we, input logic [31:0] wd);
    ev_valid = ev; ev_from = f; ev_to = t; ctl_we = we; ctl_wdata = wd;
    @(negedge clk);
    if (ev && m_ctl[0]) begin
      m_ptr = (m_ptr + 1) % 8;
      m_slot[m_ptr] = {t, f};
    end
    if (we) m_ctl = wd & 32'h0000_01C3;
    ev_valid = 1'b0; ctl_we = 1'b0;
  endtask

  task automatic sweep(input string req);
    for (int a = 0; a < 16; a++) rd_chk(4'(a), req);
  endtask

  initial begin
    n_vec = 0; n_bad = 0; done = 0;
    for (int i = 0; i < 8; i++) m_slot[i] = '0;
    m_ptr = 0; m_ctl = '0;
    rst_n = 1'b0; ev_valid = 1'b0; ev_from = '0; ev_to = '0;
    ctl_we = 1'b0; ctl_wdata = '0; rd_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    sweep("R8 reset state");

    // R4: disabled, events ignored
    for (int i = 0; i < 5; i++) cycle(1'b1, 32'hDEAD_0000 + 32'(i), 32'hBEEF_0000 + 32'(i), 1'b0, '0);
    sweep("R4 disabled events ignored");

    // R5: reserved bits dropped
    cycle(1'b0, '0, '0, 1'b1, 32'hFFFF_FFFE);
    rd_chk(4'd9, "R5 control mask");
    check("R5 control value", rd_data, 64'h1C2);
    cycle(1'b1, 32'h1111_1111, 32'h2222_2222, 1'b0, '0);
    rd_chk(4'd8, "R4 bit0 clear ignores events");

    // R9: enable written together with an event
    cycle(1'b1, 32'h3333_3333, 32'h4444_4444, 1'b1, 32'h0000_0001);
    rd_chk(4'd8, "R9 old enable qualifies event");
    check("R9 pointer still 0", rd_data, 64'd0);

    // R1 R2 R3: 21 back-to-back records, checking each
    for (int i = 0; i < 21; i++) begin
      cycle(1'b1, 32'h1000_0000 + 32'(i * 4), 32'hA000_0000 ^ 32'(i * 32'h0101_0101), 1'b0, '0);
      rd_chk(4'd8, "R3 pointer advances modulo 8");
      rd_chk(4'(m_ptr), "R2 newest slot layout");
    end
    sweep("R1 circular contents");

    // R3: first record after reset lands in slot 1
    rst_n = 1'b0;
    for (int i = 0; i < 8; i++) m_slot[i] = '0;
    m_ptr = 0; m_ctl = '0;
    @(negedge clk); rst_n = 1'b1; repeat (3) @(negedge clk);
    sweep("R8 second reset");
    cycle(1'b0, '0, '0, 1'b1, 32'h0000_0001);
    cycle(1'b1, 32'h0000_ABCD, 32'h1234_0000, 1'b0, '0);
    rd_chk(4'd1, "R3 first record in slot 1");
    check("R3 slot1 value", rd_data, 64'h1234_0000_0000_ABCD);

    // R7: read of slot written in the same cycle returns old data
    rd_addr = 4'd2;
    ev_valid = 1'b1; ev_from = 32'h5555_5555; ev_to = 32'h6666_6666;
    @(negedge clk);
    ev_valid = 1'b0;
    check("R7 same-cycle read sees old slot", rd_data, 64'd0);
    m_ptr = 2; m_slot[2] = {32'h6666_6666, 32'h5555_5555};
    rd_chk(4'd2, "R7 next read sees new slot");

    // R4: disable again
    cycle(1'b0, '0, '0, 1'b1, 32'h0000_0000);
    for (int i = 0; i < 4; i++) cycle(1'b1, 32'hFFFF_0000, 32'h0000_FFFF, 1'b0, '0);
    sweep("R6 map after disable");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule